// File: doc/BRIEF.md
# SPI FIFO Level, Status and Interrupt Unit

This unit sits beside the transmit and receive FIFOs of a serial peripheral interface controller and keeps their bookkeeping. It does not hold the data words. It counts the entries in each FIFO from four single-cycle strobes. The host side pushes transmit words and pops receive words. The serial engine pops transmit words and pushes receive words. From these two fill levels it derives a five-bit status word, five raw interrupt events, a masked copy of those events and one interrupt line.

Three of the events are error conditions: transmit overflow, receive overflow and receive underflow. Each is held in a sticky flag until software clears it through the clear register. That register has one clear bit per error plus a bit that clears all of them. The strobe inputs have no back-pressure. A push into a full FIFO is dropped and recorded, and a pop from an empty FIFO is ignored. The transmit and receive threshold registers only take values below the FIFO depth. Software can therefore find the depth by writing rising values and watching where the read-back stops following. Software normally sets each threshold to half the depth minus one.

The register bus has a write port and an independent combinational read port. Registers are addressed by word index on a 4-bit address.

Top module: `sfs_unit`

## Requirements
- R1: After reset both levels, both thresholds, the mask and all sticky flags are zero. With eng_active low, status reads 0x0C and the raw events read 0x01.
- R2: Each FIFO level rises by one on a push and falls by one on a pop. A push and a pop in the same cycle leave the level unchanged. A pop of an empty transmit FIFO changes nothing. Levels appear on tx_level and rx_level, and at addresses 2 (TX) and 3 (RX), in the cycle after the strobe.
- R3: Status bits are bit0 busy (eng_active high or TX level non-zero), bit1 TX full, bit2 TX empty, bit3 RX empty and bit4 RX full. The same word is readable at address 4.
- R4: Thresholds sit at address 0 (TX) and address 1 (RX). A write of a value below DEPTH is stored and read back unchanged. A write of DEPTH or more, including any value with bits above the threshold width, leaves the old value.
- R5: Raw event bit0 is set while the TX level is at or below the TX threshold. Raw event bit4 is set while the RX level is above the RX threshold. Both follow the levels with no memory.
- R6: A host TX push into a full TX FIFO, with no engine pop in the same cycle, is dropped and sets the sticky raw bit1. A push with a same-cycle pop at full is accepted and sets no flag.
- R7: An engine RX push into a full RX FIFO, with no host pop in the same cycle, is dropped and sets the sticky raw bit3.
- R8: A host RX pop from an empty RX FIFO sets the sticky raw bit2 and does not decrement the level. An engine push in the same cycle is still counted.
- R9: Sticky flags hold until a write to the clear register at address 8. Clear bit0 clears all flags, bit1 clears RX underflow, bit2 clears RX overflow and bit3 clears TX overflow. Zero bits have no effect.
- R10: When an error event and a clear of the same flag fall in the same cycle, the flag ends set.
- R11: The mask register at address 5 holds 5 bits. The masked events at address 7 equal the raw events (address 6) ANDed with the mask, and irq is high exactly when any masked bit is set.
- R12: The clear register and unmapped addresses (9 to 15) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write word index |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read word index |
| reg_rdata | output | 32 | Combinational read data |
| host_tx_push | input | 1 | Host wrote a TX word |
| eng_tx_pop | input | 1 | Engine took a TX word |
| eng_rx_push | input | 1 | Engine delivered an RX word |
| host_rx_pop | input | 1 | Host read an RX word |
| eng_active | input | 1 | Serial engine is shifting |
| status | output | 5 | Status word |
| irq | output | 1 | Interrupt, OR of masked events |
| tx_level | output | $clog2(DEPTH+1) | TX entry count |
| rx_level | output | $clog2(DEPTH+1) | RX entry count |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is a push and a pop on the same FIFO. The bench drives both strobes together against a full TX FIFO and against an empty RX FIFO, then expects an unchanged level with no overflow in the first case and a level of one with the underflow flag set in the second. The second pair is a clear-register write and a new error event on the same flag. The bench issues them in one cycle and expects the flag to remain set, then clears it alone and expects it to drop.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  localparam int REG_AW = 4;
  localparam int REG_DW = 32;
  localparam int EVT_W  = 5;
  localparam int STK_W  = 3;

  // register word indices
  typedef enum logic [REG_AW-1:0] {
    A_TXTHR = 4'd0,
    A_RXTHR = 4'd1,
    A_TXLVL = 4'd2,
    A_RXLVL = 4'd3,
    A_STAT  = 4'd4,
    A_MASK  = 4'd5,
    A_RAW   = 4'd6,
    A_MSTAT = 4'd7,
    A_CLR   = 4'd8
  } sfs_addr_e;

  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_TXFUL = 1;
  localparam int ST_TXEMP = 2;
  localparam int ST_RXEMP = 3;
  localparam int ST_RXFUL = 4;

  // event bit positions (raw, mask, masked)
  localparam int EV_TXLOW = 0;
  localparam int EV_TXOVF = 1;
  localparam int EV_RXUDF = 2;
  localparam int EV_RXOVF = 3;
  localparam int EV_RXHI  = 4;

  // sticky vector order follows clear bits 1..3
  localparam int SK_RXUDF = 0;
  localparam int SK_RXOVF = 1;
  localparam int SK_TXOVF = 2;

  typedef struct packed {
    logic full;
    logic empty;
    logic ovf;   // push refused while full
    logic udf;   // pop refused while empty
  } lvl_flags_t;

endpackage

// File: rtl/sfs_level_ctr.sv
module sfs_level_ctr
  import sfs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level,
  output lvl_flags_t       flags
);

  localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

  logic [LVL_W-1:0] level_q;
  logic             is_full, is_empty, pop_ok, push_ok;

  assign is_full  = (level_q == TOP);
  assign is_empty = (level_q == '0);
  assign pop_ok   = pop & ~is_empty;
  // a pop in the same cycle frees the slot a push at full needs
  assign push_ok  = push & (~is_full | pop_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
    end else begin
      unique case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + LVL_W'(1);
        2'b01:   level_q <= level_q - LVL_W'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  assign level       = level_q;
  assign flags.full  = is_full;
  assign flags.empty = is_empty;
  assign flags.ovf   = push & ~push_ok;
  assign flags.udf   = pop & is_empty;

endmodule

// File: rtl/sfs_thr_reg.sv
module sfs_thr_reg #(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [LVL_W-1:0] thr
);

  logic [LVL_W-1:0] thr_q;
  logic             fits;

  // the full write word is compared, so high garbage bits are refused too
  assign fits = (wdata < DW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n)             thr_q <= '0;
    else if (wr_en && fits) thr_q <= wdata[LVL_W-1:0];
  end

  assign thr = thr_q;

endmodule

// File: rtl/sfs_sticky.sv
module sfs_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q_r;
    always_ff @(posedge clk) begin
      if (!rst_n)      q_r <= 1'b0;
      else if (set[i]) q_r <= 1'b1;  // a fresh event beats a clear
      else if (clr[i]) q_r <= 1'b0;
    end
    assign q[i] = q_r;
  end

endmodule

// File: rtl/sfs_unit.sv
module sfs_unit
  import sfs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              host_tx_push,
  input  logic              eng_tx_pop,
  input  logic              eng_rx_push,
  input  logic              host_rx_pop,
  input  logic              eng_active,
  output logic [EVT_W-1:0]  status,
  output logic              irq,
  output logic [LVL_W-1:0]  tx_level,
  output logic [LVL_W-1:0]  rx_level
);

  localparam int PAD_L = REG_DW - LVL_W;
  localparam int PAD_E = REG_DW - EVT_W;

  lvl_flags_t       tx_f, rx_f;
  logic [LVL_W-1:0] tx_thr, rx_thr;
  logic [EVT_W-1:0] mask_q, raw_ev, masked_ev;
  logic [STK_W-1:0] stk_set, stk_clr, stk_q;
  logic             wr_txthr, wr_rxthr, wr_mask, wr_clr;

  // write decode
  assign wr_txthr = reg_wr && (reg_waddr == A_TXTHR);
  assign wr_rxthr = reg_wr && (reg_waddr == A_RXTHR);
  assign wr_mask  = reg_wr && (reg_waddr == A_MASK);
  assign wr_clr   = reg_wr && (reg_waddr == A_CLR);

  sfs_level_ctr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx_lvl (
    .clk(clk), .rst_n(rst_n), .push(host_tx_push), .pop(eng_tx_pop),
    .level(tx_level), .flags(tx_f)
  );

  sfs_level_ctr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx_lvl (
    .clk(clk), .rst_n(rst_n), .push(eng_rx_push), .pop(host_rx_pop),
    .level(rx_level), .flags(rx_f)
  );

  sfs_thr_reg #(.DEPTH(DEPTH), .LVL_W(LVL_W), .DW(REG_DW)) u_tx_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_txthr), .wdata(reg_wdata), .thr(tx_thr)
  );

  sfs_thr_reg #(.DEPTH(DEPTH), .LVL_W(LVL_W), .DW(REG_DW)) u_rx_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_rxthr), .wdata(reg_wdata), .thr(rx_thr)
  );

  // sticky error flags
  always_comb begin
    stk_set           = '0;
    stk_set[SK_RXUDF] = rx_f.udf;
    stk_set[SK_RXOVF] = rx_f.ovf;
    stk_set[SK_TXOVF] = tx_f.ovf;
    stk_clr           = wr_clr ? (reg_wdata[STK_W:1] | {STK_W{reg_wdata[0]}}) : '0;
  end

  sfs_sticky #(.N(STK_W)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set(stk_set), .clr(stk_clr), .q(stk_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[EVT_W-1:0];
  end

  // raw events: two level conditions plus three sticky flags
  always_comb begin
    raw_ev           = '0;
    raw_ev[EV_TXLOW] = (tx_level <= tx_thr);
    raw_ev[EV_TXOVF] = stk_q[SK_TXOVF];
    raw_ev[EV_RXUDF] = stk_q[SK_RXUDF];
    raw_ev[EV_RXOVF] = stk_q[SK_RXOVF];
    raw_ev[EV_RXHI]  = (rx_level > rx_thr);
  end

  assign masked_ev = raw_ev & mask_q;
  assign irq       = |masked_ev;

  always_comb begin
    status           = '0;
    status[ST_BUSY]  = eng_active | ~tx_f.empty;
    status[ST_TXFUL] = tx_f.full;
    status[ST_TXEMP] = tx_f.empty;
    status[ST_RXEMP] = rx_f.empty;
    status[ST_RXFUL] = rx_f.full;
  end

  // read multiplexer
  always_comb begin
    reg_rdata = '0;
    unique case (reg_raddr)
      A_TXTHR: reg_rdata = {{PAD_L{1'b0}}, tx_thr};
      A_RXTHR: reg_rdata = {{PAD_L{1'b0}}, rx_thr};
      A_TXLVL: reg_rdata = {{PAD_L{1'b0}}, tx_level};
      A_RXLVL: reg_rdata = {{PAD_L{1'b0}}, rx_level};
      A_STAT:  reg_rdata = {{PAD_E{1'b0}}, status};
      A_MASK:  reg_rdata = {{PAD_E{1'b0}}, mask_q};
      A_RAW:   reg_rdata = {{PAD_E{1'b0}}, raw_ev};
      A_MSTAT: reg_rdata = {{PAD_E{1'b0}}, masked_ev};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sfs_unit_chk.sv
module sfs_unit_chk
  import sfs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_waddr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic              host_tx_push,
  input logic              eng_tx_pop,
  input logic              eng_rx_push,
  input logic              host_rx_pop,
  input logic [EVT_W-1:0]  status,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic [EVT_W-1:0]  raw_ev,
  input logic [LVL_W-1:0]  tx_thr
);

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(tx_level) <= int'($past(tx_level)) + 1) &&
             (int'(tx_level) + 1 >= int'($past(tx_level))));

  // R3
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[ST_TXFUL] && status[ST_TXEMP]) && !(status[ST_RXFUL] && status[ST_RXEMP]));

  // R4
  thr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_waddr == A_TXTHR && reg_wdata >= REG_DW'(DEPTH)) |=> $stable(tx_thr));

  // R6
  tx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_TXFUL] && host_tx_push && !eng_tx_pop) |=>
      (raw_ev[EV_TXOVF] && int'(tx_level) == DEPTH));

  // R7
  rx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_RXFUL] && eng_rx_push && !host_rx_pop) |=> raw_ev[EV_RXOVF]);

  // R8
  rx_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_RXEMP] && host_rx_pop) |=> raw_ev[EV_RXUDF]);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_ev[EV_TXOVF] && !(reg_wr && reg_waddr == A_CLR && (reg_wdata[0] || reg_wdata[3])))
      |=> raw_ev[EV_TXOVF]);

endmodule

bind sfs_unit sfs_unit_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_sfs_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata), .host_tx_push(host_tx_push), .eng_tx_pop(eng_tx_pop),
  .eng_rx_push(eng_rx_push), .host_rx_pop(host_rx_pop), .status(status),
  .tx_level(tx_level), .rx_level(rx_level), .raw_ev(raw_ev), .tx_thr(tx_thr)
);

// File: tb/test_sfs_unit.sv
module test_sfs_unit;

  localparam int D  = 8;
  localparam int LW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_waddr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [3:0]    reg_raddr = '0;
  logic [31:0]   reg_rdata;
  logic          host_tx_push = 1'b0, eng_tx_pop = 1'b0;
  logic          eng_rx_push = 1'b0, host_rx_pop = 1'b0;
  logic          eng_active = 1'b0;
  logic [4:0]    status;
  logic          irq;
  logic [LW-1:0] tx_level, rx_level;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sfs_unit #(.DEPTH(D)) i_sfs_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .host_tx_push(host_tx_push), .eng_tx_pop(eng_tx_pop),
    .eng_rx_push(eng_rx_push), .host_rx_pop(host_rx_pop),
    .eng_active(eng_active), .status(status), .irq(irq),
    .tx_level(tx_level), .rx_level(rx_level)
  );

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // monitor: one register read per cycle, compared with the queued item
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        reg_raddr = e.addr;
        #1;
        check($sformatf("%s addr %0d", e.tag, e.addr), reg_rdata, e.val);
      end
    end
  end

  // driver helpers
  task automatic cyc(input logic tp, input logic tpo, input logic rpu, input logic rpo,
                     input logic wr = 1'b0, input logic [3:0] wa = 4'd0,
                     input logic [31:0] wd = 32'd0);
    @(negedge clk);
    host_tx_push = tp; eng_tx_pop = tpo; eng_rx_push = rpu; host_rx_pop = rpo;
    reg_wr = wr; reg_waddr = wa; reg_wdata = wd;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    cyc(0, 0, 0, 0, 1'b1, a, d);
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    e.addr = a; e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    host_tx_push = 0; eng_tx_pop = 0; eng_rx_push = 0; host_rx_pop = 0; reg_wr = 0;
    while (sb_q.size() > 0) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    drain();
    check("R1 tx_level", 32'(tx_level), 0);
    check("R1 rx_level", 32'(rx_level), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 status port", 32'(status), 32'h0C);
    expect_reg(0, 0, "R1"); expect_reg(1, 0, "R1"); expect_reg(5, 0, "R1");
    expect_reg(6, 32'h01, "R1"); expect_reg(7, 0, "R1"); expect_reg(4, 32'h0C, "R1");
    drain();

    // R4 thresholds: accepted below depth, refused at or above
    wreg(0, 7);          drain(); expect_reg(0, 7, "R4 accept");
    wreg(0, D);          drain(); expect_reg(0, 7, "R4 at depth");
    wreg(0, 31);         drain(); expect_reg(0, 7, "R4 above depth");
    wreg(0, 32'h102);    drain(); expect_reg(0, 7, "R4 high bits");
    wreg(0, 3); wreg(1, 3); drain();
    expect_reg(0, 3, "R4"); expect_reg(1, 3, "R4");
    drain();

    // R2 R3 R5 TX filling
    repeat (3) cyc(1, 0, 0, 0);
    drain();
    check("R2 tx_level 3", 32'(tx_level), 3);
    expect_reg(4, 32'h09, "R3 busy from data");
    expect_reg(6, 32'h01, "R5 tx at threshold");
    drain();
    cyc(1, 0, 0, 0); drain();
    expect_reg(2, 4, "R2"); expect_reg(6, 32'h00, "R5 tx above threshold");
    drain();
    repeat (4) cyc(1, 0, 0, 0);
    drain();
    expect_reg(4, 32'h0B, "R3 tx full");

    // R6 overflow, then push with pop at full
    cyc(1, 0, 0, 0); drain();
    check("R6 level held", 32'(tx_level), D);
    expect_reg(6, 32'h02, "R6 ovf set");
    drain();
    cyc(1, 1, 0, 0); drain();
    expect_reg(2, D, "R2 push+pop at full");
    wreg(8, 32'h08); drain();
    expect_reg(6, 32'h00, "R9 tx ovf cleared");
    drain();
    cyc(1, 1, 0, 0); drain();
    expect_reg(6, 32'h00, "R6 no flag with pop");
    check("R6 level", 32'(tx_level), D);

    // drain TX, extra pop on empty ignored
    repeat (9) cyc(0, 1, 0, 0);
    drain();
    check("R2 tx empty pop ignored", 32'(tx_level), 0);
    expect_reg(6, 32'h01, "R5");
    drain();
    eng_active = 1'b1; #1;
    check("R3 busy from engine", 32'(status), 32'h0D);
    eng_active = 1'b0; #1;
    check("R3 idle", 32'(status), 32'h0C);

    // R8 underflow; pop+push on empty still counts push
    cyc(0, 0, 0, 1); drain();
    expect_reg(6, 32'h05, "R8 udf set"); expect_reg(3, 0, "R8 level");
    drain();
    cyc(0, 0, 1, 1); drain();
    check("R8 push counted", 32'(rx_level), 1);
    expect_reg(6, 32'h05, "R8 flag kept");
    drain();
    wreg(8, 32'h02); drain();
    expect_reg(6, 32'h01, "R9 udf cleared");
    drain();

    // R5 R7 RX filling
    repeat (2) cyc(0, 0, 1, 0); drain();
    expect_reg(6, 32'h01, "R5 rx at threshold"); drain();
    cyc(0, 0, 1, 0); drain();
    expect_reg(6, 32'h11, "R5 rx above threshold"); drain();
    repeat (4) cyc(0, 0, 1, 0); drain();
    expect_reg(4, 32'h14, "R3 rx full"); drain();
    cyc(0, 0, 1, 0); drain();
    check("R7 level held", 32'(rx_level), D);
    expect_reg(6, 32'h19, "R7 ovf set"); drain();

    // R11 mask and irq
    wreg(5, 32'h08); drain();
    check("R11 irq on", 32'(irq), 1);
    expect_reg(7, 32'h08, "R11"); drain();
    wreg(5, 32'h00); drain();
    check("R11 irq off", 32'(irq), 0);
    wreg(5, 32'h01); drain();
    check("R11 irq level event", 32'(irq), 1);
    expect_reg(7, 32'h01, "R11"); drain();
    wreg(5, 32'h06); drain();
    check("R11 masked none", 32'(irq), 0);
    expect_reg(5, 32'h06, "R11 mask readback"); drain();

    // R9 clear behaviour
    wreg(8, 32'h01); drain();
    expect_reg(6, 32'h11, "R9 clear all"); drain();
    cyc(0, 0, 1, 0); drain();
    wreg(8, 32'h00); drain();
    expect_reg(6, 32'h19, "R9 zero clear no effect"); drain();
    wreg(8, 32'h0A); drain();
    expect_reg(6, 32'h19, "R9 other bits no effect"); drain();
    wreg(8, 32'h04); drain();
    expect_reg(6, 32'h11, "R9 rx ovf clear"); drain();

    // R10 event and clear together
    cyc(0, 0, 1, 0, 1'b1, 4'd8, 32'h04); drain();
    expect_reg(6, 32'h19, "R10 set wins"); drain();
    wreg(8, 32'h01); drain();
    expect_reg(6, 32'h11, "R10 later clear"); drain();

    // R12 read-as-zero
    expect_reg(8, 0, "R12 clear reg"); expect_reg(9, 0, "R12 unmapped");
    expect_reg(15, 0, "R12 unmapped");
    drain();

    repeat (8) cyc(0, 0, 0, 1); drain();
    check("R2 rx drained", 32'(rx_level), 0);
    expect_reg(6, 32'h01, "R5 final"); drain();

    finish_run();
  end

endmodule